// File: doc/BRIEF.md
# Round-Robin Monitor Sequencer with Alarms

This block sequences an external six-channel monitoring converter. It issues one conversion request at a time, with a channel select, and waits for a done pulse that carries the raw result. It then moves to the next channel in a fixed rotation. Each accepted result can be shifted right by a per-channel amount and is written to that channel's measurement register. The same shifted value is compared against four programmable limits: a high alarm, a low alarm, a high warning and a low warning. The comparison gives four status flags for the channel. A per-flag mask decides which flags contribute to one registered fault output.

At start-up the rotation can be limited to the temperature and supply channels. This happens when a gate input is high, or when both transmit-off inputs are high. The limit lasts until a supply result rises above the supply low-alarm limit. After that the full rotation runs until the next reset. Software uses a simple register port to program limits, shift counts and masks, and to read back measurements and flags.

Top module: `rrm_monitor`

## Requirements
- R1: After reset `conv_req` is low for the first cycle and then rises with `conv_ch` = 0. `fault` is 0. Every measurement, status, mask and shift register reads 0.
- R2: `conv_req` stays high and `conv_ch` stays stable until a cycle with `conv_done` high. That done is accepted. `conv_req` is then low for exactly one cycle and rises again with the next channel. A `conv_done` seen while `conv_req` is low is ignored.
- R3: With no start-up restriction, channels are converted in the order 0 temperature, 1 supply, 2 bias1, 3 bias2, 4 power1, 5 power2, and then back to 0.
- R4: Register 0x40 holds the shift counts: bits [2:0] for channel 2, [5:3] for channel 3, [8:6] for channel 4 and [11:9] for channel 5. Each count gives 0 to 7 logical right shifts with zero fill. Channels 0 and 1 are never shifted.
- R5: An accepted result, after its shift, is stored in the measurement register at address 0x00+channel. The register does not change otherwise.
- R6: On each accepted result, the status register at 0x10+channel is rewritten as follows: bit3 = value > high alarm, bit2 = value < low alarm, bit1 = value > high warning, bit0 = value < low warning. The value used is the shifted value, and all comparisons are strict.
- R7: The mask register at 0x48+channel has one bit per status bit, and a 1 blocks that flag. `fault` is the OR of all unblocked flags and is registered, so it follows the flags one cycle later.
- R8: While the start-up latch is set and either `boot_gate` is high or both `txoff_a` and `txoff_b` are high, the rotation alternates between channels 0 and 1. A supply result greater than the supply low-alarm limit clears the latch. The rotation then continues at channel 2, and the restriction never returns before reset. A single `txoff` input alone has no effect.
- R9: Writes to the measurement and status addresses are ignored. Reads of unmapped addresses return 0.
- R10: The limits are at address 0x20 + 4*channel + k, where k is 0 high alarm, 1 low alarm, 2 high warning, 3 low warning. They are readable. After reset the high limits read 0xFFFF and the low limits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | output | 1 | Conversion request, high while waiting for a result |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Result valid pulse from converter |
| conv_data | input | DW | Raw converter result |
| boot_gate | input | 1 | Requests start-up two-channel rotation |
| txoff_a | input | 1 | First transmit-off event |
| txoff_b | input | 1 | Second transmit-off event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| fault | output | 1 | Registered OR of unmasked flags |

## Verification
A wrong channel counter or start-up latch shows on `conv_ch` at the next request, one cycle after the accepting done. The bench checks the channel at every request against an independently tracked rotation. A shift or compare error reaches the measurement and status registers at the accepting edge, and it reaches `fault` one edge later. Every conversion is therefore read back at once. The fault pin is also sampled both before and after its one-cycle lag. Threshold sweeps probe each limit at one below, at, and one above its value.

// File: rtl/rrm_pkg.sv
`timescale 1ns/1ps
package rrm_pkg;
    localparam int NCH      = 6;
    localparam int CHW      = 3;
    localparam int NTHR     = 4;
    localparam int NFLG     = 4;
    localparam int SHW      = 3;
    localparam int FIRST_SH = 2;
    localparam int NSH      = NCH - FIRST_SH;

    // limit index inside one channel's group
    localparam int TH_HI_ALM = 0;
    localparam int TH_LO_ALM = 1;
    localparam int TH_HI_WRN = 2;
    localparam int TH_LO_WRN = 3;

    // status bit positions
    localparam int FL_LO_WRN = 0;
    localparam int FL_HI_WRN = 1;
    localparam int FL_LO_ALM = 2;
    localparam int FL_HI_ALM = 3;

    typedef enum logic [CHW-1:0] {
        CH_TEMP   = 3'd0,
        CH_SUPPLY = 3'd1,
        CH_BIAS1  = 3'd2,
        CH_BIAS2  = 3'd3,
        CH_POW1   = 3'd4,
        CH_POW2   = 3'd5
    } chan_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } sq_state_e;

    // next channel: full rotation, or the temperature/supply pair
    function automatic logic [CHW-1:0] rr_next(input logic [CHW-1:0] ch, input logic pair);
        if (pair) begin
            return (ch == CH_TEMP) ? CH_SUPPLY : CH_TEMP;
        end
        return (ch == CHW'(NCH - 1)) ? CH_TEMP : ch + 1'b1;
    endfunction
endpackage

// File: rtl/rrm_sequencer.sv
`timescale 1ns/1ps
module rrm_sequencer
    import rrm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_done,
    input  logic           restrict_req,
    input  logic           sup_above,
    output logic           conv_req,
    output logic [CHW-1:0] conv_ch,
    output logic           accept,
    output logic           restricted
);
    typedef struct packed {
        sq_state_e      state;
        logic [CHW-1:0] ch;
        logic           boot;
    } seq_t;

    seq_t q, d;
    logic boot_clear;

    always_comb begin
        d          = q;
        accept     = (q.state == SQ_BUSY) && conv_done;
        restricted = q.boot && restrict_req;
        boot_clear = accept && (q.ch == CH_SUPPLY) && sup_above;
        unique case (q.state)
            SQ_IDLE: d.state = SQ_BUSY;
            SQ_BUSY: begin
                if (conv_done) begin
                    d.state = SQ_IDLE;
                    d.ch    = rr_next(q.ch, restricted && !boot_clear);
                end
            end
        endcase
        if (boot_clear) begin
            d.boot = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= SQ_IDLE;
            q.ch    <= '0;
            q.boot  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign conv_req = (q.state == SQ_BUSY);
    assign conv_ch  = q.ch;

    p_gap_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !conv_req);
    p_req_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_req |=> conv_req);
    p_hold_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_done |=> conv_req && $stable(conv_ch));
    p_rotation_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !restricted |=> conv_ch == rr_next($past(conv_ch), 1'b0));
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ch <= CHW'(NCH - 1));
    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && restricted && conv_ch == CH_TEMP |=> conv_ch == CH_SUPPLY);
    p_boot_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.boot |=> !q.boot);
endmodule

// File: rtl/rrm_shifter.sv
`timescale 1ns/1ps
module rrm_shifter
    import rrm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]      raw,
    input  logic [CHW-1:0]     ch,
    input  logic [NSH*SHW-1:0] cfg,
    output logic [DW-1:0]      shifted
);
    logic [NCH-1:0][SHW-1:0] amt;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_amt
            if (g >= FIRST_SH) begin : g_prog
                assign amt[g] = cfg[(g-FIRST_SH)*SHW +: SHW];
            end else begin : g_fixed
                assign amt[g] = '0;
            end
        end
    endgenerate

    assign shifted = raw >> amt[ch];

    always_comb begin
        p_shift_shrinks_r4: assert (shifted <= raw);
    end
endmodule

// File: rtl/rrm_judge.sv
`timescale 1ns/1ps
module rrm_judge
    import rrm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]                value,
    input  logic [NTHR-1:0][DW-1:0]      thr,
    output logic [NFLG-1:0]              flags
);
    always_comb begin
        flags            = '0;
        flags[FL_HI_ALM] = value > thr[TH_HI_ALM];
        flags[FL_LO_ALM] = value < thr[TH_LO_ALM];
        flags[FL_HI_WRN] = value > thr[TH_HI_WRN];
        flags[FL_LO_WRN] = value < thr[TH_LO_WRN];
    end

    always_comb begin
        p_alarm_exclusive_r6: assert ((thr[TH_HI_ALM] < thr[TH_LO_ALM])
                                      || !(flags[FL_HI_ALM] && flags[FL_LO_ALM]));
    end
endmodule

// File: rtl/rrm_monitor.sv
`timescale 1ns/1ps
module rrm_monitor
    import rrm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic           conv_req,
    output logic [2:0]     conv_ch,
    input  logic           conv_done,
    input  logic [DW-1:0]  conv_data,
    input  logic           boot_gate,
    input  logic           txoff_a,
    input  logic           txoff_b,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           fault
);
    localparam int THB = $clog2(NTHR);
    localparam logic [AW-1:0] A_MEAS  = AW'('h00);
    localparam logic [AW-1:0] A_STAT  = AW'('h10);
    localparam logic [AW-1:0] A_THR   = AW'('h20);
    localparam logic [AW-1:0] A_SHIFT = AW'('h40);
    localparam logic [AW-1:0] A_MASK  = AW'('h48);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0]            meas;
        logic [NCH-1:0][NFLG-1:0]          flags;
        logic [NCH-1:0][NTHR-1:0][DW-1:0]  thr;
        logic [NSH*SHW-1:0]                shcfg;
        logic [NCH-1:0][NFLG-1:0]          mask;
        logic                              fault;
    } mon_state_t;

    mon_state_t q, d, rst_val;

    logic                      accept;
    logic                      restricted;
    logic                      sup_above;
    logic                      restrict_req;
    logic [DW-1:0]             shifted;
    logic [NFLG-1:0]           judged;
    logic [NTHR-1:0][DW-1:0]   thr_cur;
    logic [AW-1:0]             off_meas, off_stat, off_thr, off_mask;

    function automatic logic in_win(input logic [AW-1:0] a, input logic [AW-1:0] base, input int n);
        return (a >= base) && (int'(a) < int'(base) + n);
    endfunction

    assign restrict_req = boot_gate | (txoff_a & txoff_b);
    assign thr_cur      = q.thr[conv_ch];
    assign sup_above    = shifted > q.thr[CH_SUPPLY][TH_LO_ALM];

    rrm_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done    (conv_done),
        .restrict_req (restrict_req),
        .sup_above    (sup_above),
        .conv_req     (conv_req),
        .conv_ch      (conv_ch),
        .accept       (accept),
        .restricted   (restricted)
    );

    rrm_shifter #(.DW(DW)) u_shift (
        .raw     (conv_data),
        .ch      (conv_ch),
        .cfg     (q.shcfg),
        .shifted (shifted)
    );

    rrm_judge #(.DW(DW)) u_judge (
        .value (shifted),
        .thr   (thr_cur),
        .flags (judged)
    );

    assign off_meas = reg_addr - A_MEAS;
    assign off_stat = reg_addr - A_STAT;
    assign off_thr  = reg_addr - A_THR;
    assign off_mask = reg_addr - A_MASK;

    // reset image: high limits open at the top, low limits at zero
    always_comb begin
        rst_val = '0;
        for (int c = 0; c < NCH; c++) begin
            rst_val.thr[c][TH_HI_ALM] = '1;
            rst_val.thr[c][TH_HI_WRN] = '1;
        end
    end

    always_comb begin
        d = q;
        if (accept) begin
            d.meas[conv_ch]  = shifted;
            d.flags[conv_ch] = judged;
        end
        if (reg_we) begin
            if (in_win(reg_addr, A_THR, NCH*NTHR)) begin
                d.thr[off_thr[THB +: CHW]][off_thr[THB-1:0]] = reg_wdata;
            end
            if (reg_addr == A_SHIFT) begin
                d.shcfg = reg_wdata[NSH*SHW-1:0];
            end
            if (in_win(reg_addr, A_MASK, NCH)) begin
                d.mask[off_mask[CHW-1:0]] = reg_wdata[NFLG-1:0];
            end
        end
        d.fault = |(q.flags & ~q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= rst_val;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_win(reg_addr, A_MEAS, NCH)) begin
            reg_rdata = q.meas[off_meas[CHW-1:0]];
        end else if (in_win(reg_addr, A_STAT, NCH)) begin
            reg_rdata = DW'(q.flags[off_stat[CHW-1:0]]);
        end else if (in_win(reg_addr, A_THR, NCH*NTHR)) begin
            reg_rdata = q.thr[off_thr[THB +: CHW]][off_thr[THB-1:0]];
        end else if (reg_addr == A_SHIFT) begin
            reg_rdata = DW'(q.shcfg);
        end else if (in_win(reg_addr, A_MASK, NCH)) begin
            reg_rdata = DW'(q.mask[off_mask[CHW-1:0]]);
        end
    end

    assign fault = q.fault;

    p_fault_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        |(q.flags & ~q.mask) |=> fault);
    p_fault_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(q.flags & ~q.mask)) |=> !fault);
    p_meas_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(q.meas));
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(q.flags));
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(q.thr) && $stable(q.mask) && $stable(q.shcfg));
endmodule

// File: tb/rrm_monitor_test.sv
`timescale 1ns/1ps
module rrm_monitor_test;
    import rrm_pkg::*;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_req;
    logic [2:0]    conv_ch;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          boot_gate = 1'b0;
    logic          txoff_a = 1'b0;
    logic          txoff_b = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          fault;

    always #5 clk = ~clk;

    rrm_monitor #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_data(conv_data), .boot_gate(boot_gate),
        .txoff_a(txoff_a), .txoff_b(txoff_b), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault(fault)
    );

    int vectors = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] m_thr   [NCH][NTHR];
    logic [2:0]  m_sh    [NCH];
    logic [3:0]  m_mask  [NCH];
    logic [3:0]  m_flags [NCH];
    logic [15:0] m_meas  [NCH];
    int          m_ch;
    bit          m_boot;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags(input int c, input logic [15:0] v);
        logic [3:0] f;
        f[3] = v > m_thr[c][0];
        f[2] = v < m_thr[c][1];
        f[1] = v > m_thr[c][2];
        f[0] = v < m_thr[c][3];
        return f;
    endfunction

    function automatic logic exp_fault();
        logic f = 1'b0;
        for (int c = 0; c < NCH; c++) f = f | (|(m_flags[c] & ~m_mask[c]));
        return f;
    endfunction

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_thr(input int c, input int k, input logic [15:0] v);
        logic [15:0] r;
        wr(8'(8'h20 + c*4 + k), v);
        m_thr[c][k] = v;
        rd(8'(8'h20 + c*4 + k), r);
        chk("R10 limit readback", r, v);
    endtask

    task automatic set_shift(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c, input logic [2:0] e);
        logic [15:0] r;
        wr(8'h40, {4'b0, e, c, b, a});
        m_sh[2] = a; m_sh[3] = b; m_sh[4] = c; m_sh[5] = e;
        rd(8'h40, r);
        chk("R4 shift readback", r, {4'b0, e, c, b, a});
    endtask

    task automatic set_mask(input int c, input logic [3:0] v);
        wr(8'(8'h48 + c), {12'b0, v});
        m_mask[c] = v;
        @(negedge clk);
        chk("R7 masked fault", fault, exp_fault());
    endtask

    task automatic do_reset(input bit g, input bit a, input bit b);
        logic [15:0] r;
        rst_n = 1'b0; boot_gate = g; txoff_a = a; txoff_b = b;
        conv_done = 1'b0; reg_we = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NTHR; k++) m_thr[c][k] = (k % 2 == 0) ? 16'hFFFF : 16'h0000;
            m_sh[c] = '0; m_mask[c] = '0; m_flags[c] = '0; m_meas[c] = '0;
        end
        m_ch = 0; m_boot = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 request low after reset", conv_req, 0);
        chk("R1 fault after reset", fault, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(8'(c), r);          chk("R1 measurement reset", r, 0);
            rd(8'(8'h10 + c), r);  chk("R1 status reset", r, 0);
            rd(8'(8'h48 + c), r);  chk("R1 mask reset", r, 0);
            for (int k = 0; k < NTHR; k++) begin
                rd(8'(8'h20 + c*4 + k), r);
                chk("R10 limit reset", r, m_thr[c][k]);
            end
        end
        rd(8'h40, r); chk("R1 shift reset", r, 0);
        chk("R1 first request", conv_req, 1);
        chk("R1 first channel", conv_ch, 0);
    endtask

    task automatic serve(input logic [15:0] v, input int lat, input bit stray);
        string tg;
        int c;
        logic [15:0] sv, r;
        logic of;
        while (conv_req !== 1'b1) @(negedge clk);
        tg = (m_boot && (boot_gate || (txoff_a && txoff_b))) ? "R8 restricted order" : "R3 rotation order";
        chk(tg, conv_ch, m_ch);
        repeat (lat) begin
            @(negedge clk);
            chk("R2 request held", conv_req, 1);
        end
        conv_done = 1'b1; conv_data = v;
        @(negedge clk);
        if (stray) conv_data = ~v; else conv_done = 1'b0;
        c = m_ch;
        sv = v >> m_sh[c];
        of = exp_fault();
        m_meas[c] = sv;
        m_flags[c] = exp_flags(c, sv);
        if (c == 1 && sv > m_thr[1][1]) m_boot = 0;
        if (m_boot && (boot_gate || (txoff_a && txoff_b))) m_ch = (c == 0) ? 1 : 0;
        else m_ch = (c == NCH - 1) ? 0 : c + 1;
        chk("R2 request drops after done", conv_req, 0);
        chk("R7 fault lags flags", fault, of);
        @(negedge clk);
        conv_done = 1'b0;
        chk("R2 next request", conv_req, 1);
        chk("R7 fault", fault, exp_fault());
        rd(8'(c), r);
        chk(c >= 2 ? "R4 shifted measurement" : "R5 measurement", r, sv);
        rd(8'(8'h10 + c), r);
        chk("R6 status flags", r, {12'b0, m_flags[c]});
    endtask

    task automatic serve_to(input int target, input logic [15:0] v);
        while (m_ch != target) serve(16'h4000, 0, 0);
        serve(v, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r, r0;

        // R8: gate input holds the pair rotation until supply exceeds its low alarm
        do_reset(1, 0, 0);
        set_thr(1, 1, 16'd1000);
        serve(16'd100, 0, 0);
        serve(16'd900, 1, 0);
        serve(16'd200, 0, 1);
        serve(16'd1000, 2, 0);
        serve(16'd300, 0, 0);
        serve(16'd1001, 0, 0);
        for (int i = 0; i < 8; i++) serve(16'(5 + i), 0, 0);

        // R8: both transmit-off events restrict; one alone does not
        do_reset(0, 1, 1);
        set_thr(1, 1, 16'd50000);
        for (int i = 0; i < 6; i++) serve(16'(16'h4000 + i), 0, 0);
        serve(16'd7, 0, 0);
        serve(16'd60000, 0, 0);
        for (int i = 0; i < 5; i++) serve(16'h0100, 0, 0);
        do_reset(0, 1, 0);
        set_thr(1, 1, 16'd50000);
        for (int i = 0; i < 8; i++) serve(16'h0100, 1, 0);

        // R4/R5: every shift count on every shiftable channel
        do_reset(0, 0, 0);
        for (int s = 0; s < 8; s++) begin
            set_shift(3'(s), 3'(s + 1), 3'(s + 2), 3'(s + 3));
            for (int k = 0; k < NCH; k++) serve(16'hFFFF - 16'((s*6 + k) * 1873), 0, 0);
        end

        // R6: boundary sweep on the temperature limits
        set_shift(0, 0, 0, 0);
        set_thr(0, 0, 16'h8000);
        set_thr(0, 1, 16'h1000);
        set_thr(0, 2, 16'h7000);
        set_thr(0, 3, 16'h2000);
        serve_to(0, 16'h0000);
        for (int t = 0; t < 4; t++) begin
            for (int dl = -1; dl <= 1; dl++) begin
                serve_to(0, 16'((t == 0 ? 16'h1000 : t == 1 ? 16'h2000 : t == 2 ? 16'h7000 : 16'h8000) + dl));
            end
        end
        // R6 with R4: compare uses the shifted value
        set_shift(2, 0, 0, 0);
        set_thr(2, 0, 16'h0100);
        serve_to(2, 16'h0400);
        serve_to(2, 16'h0404);
        serve_to(2, 16'h0403);

        // R7: masking of individual flags
        serve_to(0, 16'hFFFF);
        set_mask(0, 4'b1010);
        set_mask(0, 4'b1000);
        set_mask(0, 4'b0010);
        set_mask(0, 4'b1111);
        set_mask(0, 4'b0000);

        // R9: read-only and unmapped addresses
        rd(8'h00, r0);
        wr(8'h00, 16'h1234);
        rd(8'h00, r);  chk("R9 measurement write ignored", r, m_meas[0]);
        wr(8'h10, 16'h000F);
        rd(8'h10, r);  chk("R9 status write ignored", r, {12'b0, m_flags[0]});
        rd(8'h7F, r);  chk("R9 unmapped read", r, 0);
        rd(8'h4E, r);  chk("R9 unmapped read", r, 0);
        rd(8'h38, r);  chk("R9 unmapped read", r, 0);
        chk("R5 measurement unchanged", r0, m_meas[0]);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule